// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of already-filtered input pins and turns pin activity into per-pin event flags plus one combined interrupt line. Each pin is sampled on every clock. The new sample is compared with the one before it. By default any change of a pin is an event. The pin's configuration elsewhere in the chip (plain input, driven by the controller, or handed to a peripheral) does not matter.

A per-pin extra-mode mask replaces any-change detection with one chosen condition. Two further per-pin selects pick that condition: a kind select chooses between edge and level, and a polarity select chooses between rising/high and falling/low. Events are latched in a status register that empties when it is read. The interrupt output is raised when a latched event belongs to a pin whose enable bit is set.

Software reaches the block through a simple register port with one-cycle write and read strobes. Every mask has a set address and a clear address. In both, a 1 in the written word acts on that bit and a 0 leaves the bit alone. The read data is registered, so it is valid one cycle after the read strobe.

Top module: `pin_event_irq`

## Requirements
- R1: Writing to address 0 sets the enable bits where the written word has a 1. Writing to address 1 clears the enable bits where the written word has a 1. Reading address 0, 1 or 2 returns the enable mask.
- R2: Three more masks work the same way. The extra-mode mask uses addresses 3 (set), 4 (clear) and 5 (read). The kind select uses 6, 7 and 8, where 1 means level. The polarity select uses 9, 10 and 11, where 1 means rising or high.
- R3: When a pin's extra-mode bit is 0, any difference between the pin's sample and the previous sample sets that pin's status bit at that clock edge.
- R4: In extra mode with kind=edge and polarity=1, only a 0-to-1 transition sets the status bit.
- R5: In extra mode with kind=edge and polarity=0, only a 1-to-0 transition sets the status bit.
- R6: In extra mode with kind=level and polarity=1, the status bit is set on every clock the pin is high, so it comes back right after a read while the pin stays high.
- R7: In extra mode with kind=level and polarity=0, the status bit is set on every clock the pin is low.
- R8: Status bits are set whether or not the pin is enabled. The interrupt output is 1 exactly when the status register ANDed with the enable mask is nonzero, and it is updated in the same cycle as the status register.
- R9: Reading address 12 returns the status register as it was before the read, then clears it. An event detected in the read cycle itself is kept.
- R10: Synchronous reset clears all four masks and the status register. It also takes the current pins as the previous sample, so pins that are high at reset do not produce an event.
- R11: A 0 bit written to any set or clear address leaves the corresponding mask bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N | Filtered pin values |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | N | Write data |
| rdata | output | N | Registered read data, valid the cycle after rd_en |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench checks that pins held high through reset raise no event. A design that missed this would report a burst of false edges as soon as reset is released. It also checks that a level condition comes back right after a status read. A design that latched levels only as edges would go quiet after that read.

An event that arrives in the same cycle as a status read must survive the clear. A design that gave the clear priority would lose that event. The bench also checks that disabled pins still latch status while leaving the interrupt low, and that writing zero words changes no mask. Either mistake shows up as a wrong mask readback or a wrong interrupt level.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_IEN_SET = 4'd0,
    A_IEN_CLR = 4'd1,
    A_IEN_RD  = 4'd2,
    A_XM_SET  = 4'd3,
    A_XM_CLR  = 4'd4,
    A_XM_RD   = 4'd5,
    A_LVL_SET = 4'd6,
    A_LVL_CLR = 4'd7,
    A_LVL_RD  = 4'd8,
    A_POL_SET = 4'd9,
    A_POL_CLR = 4'd10,
    A_POL_RD  = 4'd11,
    A_STAT    = 4'd12
  } reg_addr_e;

  // Mask index in the config bank
  localparam int CFG_IEN = 0;
  localparam int CFG_XM  = 1;
  localparam int CFG_LVL = 2;
  localparam int CFG_POL = 3;
  localparam int CFG_NUM = 4;
  // Addresses per config mask: set, clear, read
  localparam int CFG_STRIDE = 3;
endpackage

// File: rtl/pei_mask_reg.sv
module pei_mask_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_nxt
);
  logic [N-1:0] set_bits;
  logic [N-1:0] clr_bits;

  always_comb begin
    set_bits = set_we ? wdata : '0;
    clr_bits = clr_we ? wdata : '0;
    mask_nxt = (mask_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end
endmodule

// File: rtl/pei_detect.sv
module pei_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] xm,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] pol,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] prev_q;

  // Reset loads the live pins so no edge appears on release
  always_ff @(posedge clk) begin
    prev_q <= pin_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise, fall, any, cond;
    always_comb begin
      rise = pin_i[i] & ~prev_q[i];
      fall = ~pin_i[i] & prev_q[i];
      any  = pin_i[i] ^ prev_q[i];
      if (!xm[i])      cond = any;
      else if (lvl[i]) cond = pol[i] ? pin_i[i] : ~pin_i[i];
      else             cond = pol[i] ? rise : fall;
      hit_o[i] = cond & ~rst;
    end
  end
endmodule

// File: rtl/pei_status.sv
module pei_status #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic         clr_rd,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] stat_nxt
);
  // New hits take priority over the read clear
  always_comb begin
    stat_nxt = (clr_rd ? '0 : stat_q) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pei_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  output logic              irq_o
);
  logic [N-1:0] cfg_q   [CFG_NUM];
  logic [N-1:0] cfg_nxt [CFG_NUM];
  logic [N-1:0] hit;
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_nxt;
  logic         clr_rd;
  logic [N-1:0] rd_mux;

  for (genvar g = 0; g < CFG_NUM; g++) begin : g_cfg
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(CFG_STRIDE * g);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CFG_STRIDE * g + 1);
    pei_mask_reg #(.N(N)) u_mask (
      .clk     (clk),
      .rst     (rst),
      .set_we  (wr_en && addr == SET_A),
      .clr_we  (wr_en && addr == CLR_A),
      .wdata   (wdata),
      .mask_q  (cfg_q[g]),
      .mask_nxt(cfg_nxt[g])
    );
  end

  pei_detect #(.N(N)) u_det (
    .clk  (clk),
    .rst  (rst),
    .pin_i(pin_i),
    .xm   (cfg_q[CFG_XM]),
    .lvl  (cfg_q[CFG_LVL]),
    .pol  (cfg_q[CFG_POL]),
    .hit_o(hit)
  );

  assign clr_rd = rd_en && (addr == A_STAT);

  pei_status #(.N(N)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .clr_rd  (clr_rd),
    .stat_q  (stat_q),
    .stat_nxt(stat_nxt)
  );

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < CFG_NUM; g++) begin
      if (int'(addr) >= CFG_STRIDE * g && int'(addr) < CFG_STRIDE * (g + 1))
        rd_mux = cfg_q[g];
    end
    if (addr == A_STAT) rd_mux = stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_o <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq_o <= |(stat_nxt & cfg_nxt[CFG_IEN]);
    end
  end
endmodule

// File: rtl/pei_checker.sv
module pei_checker
  import pei_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      wdata,
  input logic [N-1:0]      rdata,
  input logic [N-1:0]      pin_i,
  input logic              irq_o,
  input logic [N-1:0]      stat_q,
  input logic [N-1:0]      ien_q,
  input logic [N-1:0]      xm_q
);
  logic [N-1:0] pin_d;
  logic         armed;
  logic [N-1:0] dflt_chg;

  always_ff @(posedge clk) begin
    pin_d <= pin_i;
    armed <= !rst;
  end

  assign dflt_chg = (pin_i ^ pin_d) & ~xm_q;

  assert_irq_matches_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(stat_q & ien_q));

  assert_ien_set_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_IEN_SET) |=> ((ien_q & $past(wdata)) == $past(wdata)));

  assert_ien_clr_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_IEN_CLR) |=> ((ien_q & $past(wdata)) == '0));

  assert_xm_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_XM_SET) |=> ((xm_q & $past(wdata)) == $past(wdata)));

  assert_read_old_status_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT) |=> (rdata == $past(stat_q)));

  assert_any_edge_latched_R3: assert property (@(posedge clk) disable iff (rst)
    armed |=> ((stat_q & $past(dflt_chg)) == $past(dflt_chg)));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && ien_q == '0 && xm_q == '0));
endmodule

bind pin_event_irq pei_checker #(.N(N)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .pin_i (pin_i),
  .irq_o (irq_o),
  .stat_q(stat_q),
  .ien_q (cfg_q[0]),
  .xm_q  (cfg_q[1])
);

// File: tb/sim_pin_event_irq.sv
`timescale 1ns/1ps
module sim_pin_event_irq;
  localparam int N = 32;
  localparam int NV = 6;
  // {pin pattern, expected status after it}; status = pattern ^ previous pattern
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_00FF, 32'h0000_00FF},
    {32'h0000_0F0F, 32'h0000_0FF0},
    {32'hF000_0F0F, 32'hF000_0000},
    {32'h0000_0000, 32'hF000_0F0F},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h5555_5555, 32'hAAAA_AAAA}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_i = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq_o;
  int           errors = 0;
  int           checks = 0;
  logic [N-1:0] v;

  always #2.5 clk = ~clk;

  pin_event_irq #(.N(N)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic setpin(input logic [N-1:0] p);
    @(negedge clk); pin_i = p;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [N-1:0] p);
    @(negedge clk); rst = 1'b1; pin_i = p;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: pins high through reset give no event
    do_reset('1);
    check("R10 irq after reset", {31'b0, irq_o}, '0);
    rd(4'd12, v); check("R10 status after reset", v, '0);
    rd(4'd2, v);  check("R10 enable mask after reset", v, '0);
    rd(4'd5, v);  check("R10 extra mask after reset", v, '0);
    setpin('0);
    rd(4'd12, v); check("R3 all pins fall", v, '1);

    // R3: table of default-mode patterns
    for (int k = 0; k < NV; k++) begin
      setpin(VEC[k][63:32]);
      rd(4'd12, v);
      check($sformatf("R3 vector %0d", k), v, VEC[k][31:0]);
    end
    setpin('0);
    rd(4'd12, v);

    // R2: mask readback through set/clear
    wr(4'd3, 32'hFFFF_0000); wr(4'd4, 32'h0F00_0000);
    rd(4'd5, v); check("R2 extra mask", v, 32'hF0FF_0000);
    wr(4'd6, 32'h0000_00F0); rd(4'd8, v); check("R2 kind mask", v, 32'h0000_00F0);
    wr(4'd9, 32'h0000_0F00); rd(4'd11, v); check("R2 polarity mask", v, 32'h0000_0F00);
    wr(4'd4, '1); wr(4'd7, '1); wr(4'd10, '1);
    rd(4'd5, v); check("R2 extra mask cleared", v, '0);

    // R6: high level on pin 2
    wr(4'd6, 32'h4); wr(4'd9, 32'h4); wr(4'd3, 32'h4);
    rd(4'd12, v); check("R6 no level while low", v, '0);
    setpin(32'h4);
    rd(4'd12, v); check("R6 high level", v, 32'h4);
    rd(4'd12, v); check("R6 level returns after read", v, 32'h4);
    setpin('0);
    rd(4'd12, v);
    rd(4'd12, v); check("R6 gone when low", v, '0);

    // R7: low level on pin 2
    wr(4'd10, 32'h4);
    rd(4'd12, v); check("R7 low level", v, 32'h4);
    setpin(32'h4);
    rd(4'd12, v);
    rd(4'd12, v); check("R7 gone when high", v, '0);

    // R4: rising edge only
    wr(4'd7, 32'h4); wr(4'd9, 32'h4);
    setpin('0);
    rd(4'd12, v); check("R4 fall ignored", v, '0);
    setpin(32'h4);
    rd(4'd12, v); check("R4 rise seen", v, 32'h4);

    // R5: falling edge only
    wr(4'd10, 32'h4);
    setpin('0);
    rd(4'd12, v); check("R5 fall seen", v, 32'h4);
    setpin(32'h4);
    rd(4'd12, v); check("R5 rise ignored", v, '0);

    // back to default
    wr(4'd4, 32'h4);
    setpin('0);
    rd(4'd12, v); check("R3 default after extra cleared", v, 32'h4);

    // R1 / R8: enable and interrupt
    wr(4'd0, 32'h8);
    rd(4'd2, v); check("R1 enable set", v, 32'h8);
    setpin(32'h20);
    check("R8 disabled pin no irq", {31'b0, irq_o}, '0);
    rd(4'd12, v); check("R8 disabled pin still latched", v, 32'h20);
    setpin(32'h28);
    check("R8 enabled pin irq", {31'b0, irq_o}, 32'h1);
    rd(4'd12, v); check("R9 status read", v, 32'h08);
    check("R9 irq drops after read", {31'b0, irq_o}, '0);

    // R11: zero writes change nothing
    wr(4'd0, '0); rd(4'd1, v); check("R11 zero set write", v, 32'h8);
    wr(4'd1, '0); rd(4'd0, v); check("R11 zero clear write", v, 32'h8);
    wr(4'd1, 32'h8); rd(4'd2, v); check("R1 enable clear", v, '0);

    // R9: event in read cycle survives the clear
    @(negedge clk); rd_en = 1'b1; addr = 4'd12; pin_i = '0;
    @(negedge clk); rd_en = 1'b0;
    check("R9 read before event", rdata, '0);
    rd(4'd12, v); check("R9 event kept across clear", v, 32'h28);

    // R10: second reset with masks set
    wr(4'd0, 32'hFF); wr(4'd3, 32'hF0);
    do_reset(32'hA5A5_A5A5);
    rd(4'd12, v); check("R10 status after second reset", v, '0);
    rd(4'd0, v);  check("R10 enable cleared", v, '0);
    rd(4'd5, v);  check("R10 extra cleared", v, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule